// File: doc/BRIEF.md
# Multi-Channel Even-Spread Step Generator

This block decides, on every tick period, whether each of several independent channels emits a step. Each channel is programmed with a frame length X and a step count Y (Y no greater than X). It then spreads its Y steps across each run of X ticks as evenly as a straight line is drawn on a raster. Only integer addition, comparison and subtraction are used. A doubled accumulator is seeded at half a step, so no fraction and no division ever appear.

After every X ticks the channel reseeds itself and pulses a frame-done flag, so the same pattern repeats without drift. The per-tick step vector of all channels forms one entry of an external ring buffer. The block produces the write strobe and a wrapping write address for that buffer, and the step vector itself is the entry data. A load whose Y exceeds its X is refused: the channel keeps its running pattern and raises an error flag. A channel with X equal to zero stays idle.

Top module: `step_spread_gen`

## Requirements
- R1: A load on channel c with ld_y ≤ ld_x is accepted: the accumulator becomes X, the tick count within the frame becomes 0, and err[c] is cleared one cycle later.
- R2: On each tick, a running channel adds 2Y to its accumulator. When the sum is at least 2X, it subtracts 2X and sets step[c] to 1 in the next cycle; otherwise step[c] is 0. With X=10 and Y=5 the pattern is step, no step, alternating, starting with a step.
- R3: Over every frame of exactly X ticks, a channel emits exactly Y steps. In the cycle after the X-th tick, frame_done[c] is 1 and the accumulator is reseeded to X.
- R4: Y=0 gives no steps at all, and Y=X gives a step on every tick.
- R5: A load with ld_y > ld_x is rejected. err[c] becomes 1 and the previous X and Y keep driving the pattern unchanged.
- R6: A channel whose accepted X is 0, including every channel after reset, emits neither steps nor frame_done.
- R7: step[c] and frame_done[c] are single-cycle flags. They can be 1 only in the cycle after a tick in which that channel had no load.
- R8: In the cycle after each tick, buf_we is 1 and buf_addr holds the ring slot for that tick's step vector. Slots start at 0 after reset and advance by one per tick, wrapping modulo DEPTH (256). buf_we is 0 after a cycle without a tick.
- R9: Synchronous active-low reset clears all steps, frame_done, err and buf_we, and sets every channel to X=0.
- R10: A load takes priority over a tick on the same channel in the same cycle. That channel emits no step for that cycle, and its new pattern starts from the next tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Period enable shared by all channels |
| load | input | NCH (4) | Per-channel load strobe |
| ld_x | input | NCH*XW (64) | Frame length X, channel c in bits [c*XW +: XW] |
| ld_y | input | NCH*XW (64) | Step count Y, channel c in bits [c*XW +: XW] |
| step | output | NCH (4) | Step flag per channel; also the ring entry data |
| frame_done | output | NCH (4) | One-cycle end-of-frame flag per channel |
| err | output | NCH (4) | Set by a rejected load, cleared by an accepted one |
| buf_we | output | 1 | Ring buffer write strobe |
| buf_addr | output | $clog2(DEPTH) (8) | Ring buffer write slot |

## Verification
On every cycle, the embedded properties check the following:
- the accumulator stays below 2X and the frame count below X;
- accepted loads seed the channel and rejected loads leave X and Y untouched;
- idle channels stay quiet, and steps and frame flags only follow a tick;
- the write strobe tracks the tick and the address matches the slot pointer.

Only the bench scenarios can show that the step sequence is the evenly spread one, that each frame holds exactly Y steps, and that the Y=0 and Y=X extremes, the alternating X=10/Y=5 pattern, a rejected load mid-run and a load colliding with a tick all behave as specified.

// File: rtl/sg_pkg.sv
// Shared defaults for the even-spread step generator.
// Assumes: consumers take these only as parameter defaults.
package sg_pkg;
    localparam int DEF_NCH   = 4;    // number of independent channels
    localparam int DEF_XW    = 16;   // width of X and Y
    localparam int DEF_DEPTH = 256;  // ring buffer depth in entries
endpackage

// File: rtl/sg_lane.sv
// One channel: doubled-integer accumulator spreading Y steps over X ticks.
// Assumes: ld_x/ld_y are sampled only when load is high; tick is a one-cycle
// enable per period. Outputs are registered (one cycle after the tick).
module sg_lane #(
    parameter int XW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [XW-1:0] ld_x,
    input  logic [XW-1:0] ld_y,
    input  logic          tick,
    output logic          step,
    output logic          frame_done,
    output logic          err
);
    localparam int AW = XW + 1;   // holds 2X
    localparam int SW = XW + 2;   // holds acc + 2Y

    logic [AW-1:0] x2_q, y2_q, acc_q;
    logic [XW-1:0] cnt_q;
    logic          step_q, done_q, err_q;

    logic [SW-1:0] sum;
    logic          hit, last, running, bad_ld;
    logic [AW-1:0] acc_nxt;

    // Next-accumulator arithmetic for one tick.
    always_comb begin
        sum     = {1'b0, acc_q} + {1'b0, y2_q};
        hit     = sum >= {1'b0, x2_q};
        acc_nxt = hit ? AW'(sum - {1'b0, x2_q}) : AW'(sum);
        last    = cnt_q == XW'(x2_q[XW:1] - 1'b1);
        running = x2_q != '0;
        bad_ld  = ld_y > ld_x;
    end

    // Load handling, tick stepping and frame reseed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x2_q   <= '0;
            y2_q   <= '0;
            acc_q  <= '0;
            cnt_q  <= '0;
            step_q <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            step_q <= 1'b0;
            done_q <= 1'b0;
            if (load) begin
                if (bad_ld) begin
                    err_q <= 1'b1;
                end else begin
                    x2_q  <= {ld_x, 1'b0};
                    y2_q  <= {ld_y, 1'b0};
                    acc_q <= {1'b0, ld_x};
                    cnt_q <= '0;
                    err_q <= 1'b0;
                end
            end else if (tick && running) begin
                step_q <= hit;
                if (last) begin
                    acc_q  <= {1'b0, x2_q[XW:1]};
                    cnt_q  <= '0;
                    done_q <= 1'b1;
                end else begin
                    acc_q <= acc_nxt;
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign step       = step_q;
    assign frame_done = done_q;
    assign err        = err_q;

    // R1: accepted load seeds the channel at X with a fresh frame count
    p_seed_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !bad_ld) |=> (acc_q == {1'b0, $past(ld_x)} && cnt_q == '0 && !err_q && !step_q));
    // R2: accumulator always below 2X while running
    p_acc_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (acc_q < x2_q));
    // R3: frame position stays inside the frame
    p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cnt_q < x2_q[XW:1]));
    // R5: rejected load leaves the pattern untouched and flags an error
    p_reject_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (load && bad_ld) |=> ($stable(x2_q) && $stable(y2_q) && err_q));
    // R6: idle channel stays quiet
    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !load) |=> (!step_q && !done_q));
    // R7: flags only follow a tick without a load
    p_flag_after_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q || done_q) |-> $past(tick && !load));
endmodule

// File: rtl/sg_ring_wr.sv
// Write side of the step ring buffer: strobe and wrapping slot address.
// Assumes: one entry per tick; the entry data is the step vector, which
// becomes valid in the same cycle as the strobe.
module sg_ring_wr #(
    parameter int DEPTH = 256
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick,
    output logic                     we,
    output logic [$clog2(DEPTH)-1:0] addr
);
    localparam int AW = $clog2(DEPTH);

    logic [AW-1:0] ptr_q, addr_q;
    logic          we_q;

    // Advance the slot pointer once per tick and present the used slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            addr_q <= '0;
            we_q   <= 1'b0;
        end else begin
            we_q <= tick;
            if (tick) begin
                addr_q <= ptr_q;
                ptr_q  <= (ptr_q == AW'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
            end
        end
    end

    assign we   = we_q;
    assign addr = addr_q;

    // R8: strobe follows the tick by one cycle
    p_we_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> we_q);
    p_we_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> !we_q);
    // R8: the pointer has moved one slot past the written address
    p_addr_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        we_q |-> (ptr_q == ((addr_q == AW'(DEPTH - 1)) ? '0 : AW'(addr_q + 1'b1))));
endmodule

// File: rtl/step_spread_gen.sv
// Top: NCH independent even-spread step channels sharing one tick, plus the
// ring buffer write side. Assumes the external buffer stores 'step' at
// buf_addr whenever buf_we is high.
module step_spread_gen #(
    parameter int NCH   = sg_pkg::DEF_NCH,
    parameter int XW    = sg_pkg::DEF_XW,
    parameter int DEPTH = sg_pkg::DEF_DEPTH
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick,
    input  logic [NCH-1:0]           load,
    input  logic [NCH*XW-1:0]        ld_x,
    input  logic [NCH*XW-1:0]        ld_y,
    output logic [NCH-1:0]           step,
    output logic [NCH-1:0]           frame_done,
    output logic [NCH-1:0]           err,
    output logic                     buf_we,
    output logic [$clog2(DEPTH)-1:0] buf_addr
);
    // One lane per channel.
    for (genvar c = 0; c < NCH; c++) begin : g_lane
        sg_lane #(.XW(XW)) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (load[c]),
            .ld_x       (ld_x[c*XW +: XW]),
            .ld_y       (ld_y[c*XW +: XW]),
            .tick       (tick),
            .step       (step[c]),
            .frame_done (frame_done[c]),
            .err        (err[c])
        );
    end

    // Ring slot generation.
    sg_ring_wr #(.DEPTH(DEPTH)) u_ring (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .we    (buf_we),
        .addr  (buf_addr)
    );
endmodule

// File: tb/sim_step_spread_gen.sv
`timescale 1ns/1ps
module sim_step_spread_gen;
    localparam int NCH = 4;
    localparam int XW = 16;
    localparam int DEPTH = 256;
    localparam int AW = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic [NCH-1:0] load = '0;
    logic [NCH*XW-1:0] ld_x = '0, ld_y = '0;
    logic [NCH-1:0] step, frame_done, err;
    logic buf_we;
    logic [AW-1:0] buf_addr;

    always #2.5 clk = ~clk;

    step_spread_gen #(.NCH(NCH), .XW(XW), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(load), .ld_x(ld_x), .ld_y(ld_y),
        .step(step), .frame_done(frame_done), .err(err), .buf_we(buf_we), .buf_addr(buf_addr)
    );

    int checks = 0, failures = 0;
    bit finished = 0;

    // bench model state (from the requirements)
    int mx[NCH], my[NCH], macc[NCH], mcnt[NCH], merr[NCH];
    int mptr = 0;
    int fsteps[NCH];
    // pending load request
    int lx[NCH], ly[NCH];
    bit lm[NCH];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one cycle: drive at negedge, model and compare just after posedge
    task automatic go(input bit t);
        int es, ed;
        @(negedge clk);
        tick = t;
        for (int c = 0; c < NCH; c++) begin
            load[c] = lm[c];
            ld_x[c*XW +: XW] = XW'(lx[c]);
            ld_y[c*XW +: XW] = XW'(ly[c]);
        end
        @(posedge clk);
        #1;
        for (int c = 0; c < NCH; c++) begin
            es = 0; ed = 0;
            if (lm[c]) begin
                if (ly[c] > lx[c]) merr[c] = 1;
                else begin
                    mx[c] = lx[c]; my[c] = ly[c]; macc[c] = lx[c]; mcnt[c] = 0; merr[c] = 0;
                    fsteps[c] = 0;
                end
            end else if (t && mx[c] != 0) begin
                int s;
                s = macc[c] + 2 * my[c];
                if (s >= 2 * mx[c]) begin es = 1; s = s - 2 * mx[c]; end
                if (mcnt[c] == mx[c] - 1) begin
                    macc[c] = mx[c]; mcnt[c] = 0; ed = 1;
                end else begin
                    macc[c] = s; mcnt[c]++;
                end
            end
            chk(step[c] == es[0], $sformatf("R2/R7 step ch%0d", c), step[c], es);
            chk(frame_done[c] == ed[0], $sformatf("R3/R7 frame_done ch%0d", c), frame_done[c], ed);
            chk(err[c] == merr[c][0], $sformatf("R5/R1 err ch%0d", c), err[c], merr[c]);
            fsteps[c] += step[c];
            if (frame_done[c]) begin
                chk(fsteps[c] == my[c], $sformatf("R3 steps per frame ch%0d", c), fsteps[c], my[c]);
                fsteps[c] = 0;
            end
            lm[c] = 0;
        end
        chk(buf_we == t, "R8 buf_we", buf_we, t);
        if (t) begin
            chk(buf_addr == AW'(mptr), "R8 buf_addr", buf_addr, mptr);
            mptr = (mptr + 1) % DEPTH;
        end
    endtask

    task automatic req(input int c, input int x, input int y);
        lm[c] = 1; lx[c] = x; ly[c] = y;
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 12345;
        void'($urandom(seed));
        for (int c = 0; c < NCH; c++) begin
            mx[c] = 0; my[c] = 0; macc[c] = 0; mcnt[c] = 0; merr[c] = 0;
            fsteps[c] = 0; lm[c] = 0; lx[c] = 0; ly[c] = 0;
        end
        repeat (3) @(posedge clk);
        #1;
        // R9: reset state
        chk(step == '0, "R9 step at reset", step, 0);
        chk(frame_done == '0, "R9 frame_done at reset", frame_done, 0);
        chk(err == '0, "R9 err at reset", err, 0);
        chk(buf_we == 1'b0, "R9 buf_we at reset", buf_we, 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R6: idle channels after reset, R8 slot 0 first
        go(1); go(1); go(0);
        chk(step == '0, "R6 idle no steps", step, 0);

        // directed patterns: R1 R2 R4
        req(0, 10, 5); req(1, 10, 3); req(2, 10, 0); req(3, 7, 7);
        go(0);
        for (int k = 0; k < 20; k++) begin
            go(1);
            chk(step[0] == ((k % 2) == 0), "R2 X=10 Y=5 alternating", step[0], (k % 2) == 0);
            chk(step[2] == 1'b0, "R4 Y=0 never steps", step[2], 0);
            chk(step[3] == 1'b1, "R4 Y=X steps every tick", step[3], 1);
        end
        // R7: no tick gives no flags
        go(0);
        chk(step == '0 && frame_done == '0, "R7 no tick no flags", step, 0);

        // R5: rejected load mid-run
        for (int k = 0; k < 4; k++) go(1);
        req(1, 4, 9);
        go(1);
        chk(err[1] == 1'b1, "R5 reject raises err", err[1], 1);
        for (int k = 0; k < 15; k++) go(1);

        // R10: load collides with tick on ch1
        req(1, 10, 10);
        go(1);
        chk(step[1] == 1'b0, "R10 load beats tick", step[1], 0);
        chk(err[1] == 1'b0, "R1 accepted load clears err", err[1], 0);
        go(1);
        chk(step[1] == 1'b1, "R10 new pattern from next tick", step[1], 1);

        // R6: X=0 load returns a channel to idle
        req(2, 0, 0);
        go(1);
        for (int k = 0; k < 5; k++) begin
            go(1);
            chk(step[2] == 1'b0 && frame_done[2] == 1'b0, "R6 X=0 idle", step[2], 0);
        end

        // X=1 corner: frame every tick
        req(3, 1, 1); req(0, 1, 0);
        go(0);
        for (int k = 0; k < 4; k++) go(1);

        // random phase with gaps and occasional (sometimes bad) loads
        for (int n = 0; n < 4000; n++) begin
            for (int c = 0; c < NCH; c++) begin
                if ($urandom_range(0, 59) == 0) begin
                    int x;
                    x = $urandom_range(0, 24);
                    req(c, x, $urandom_range(0, x + 2));
                end
            end
            go($urandom_range(0, 9) < 7);
        end
        // R8: wrap check over a full ring already covered above; final idle
        go(0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule